// File: doc/BRIEF.md
# H-Bridge Gate Sequencer with Dead Time

This block converts a PWM signal and a direction signal from a host microcontroller into four gate-enable outputs for a full bridge of external power transistors. The bridge has two legs. Each leg has a high-side and a low-side switch. In the driven leg the high side follows PWM and the low side takes the complement. In the other leg the high side is held off and the low side is held on, so that current can recirculate. A programmable dead time is inserted whenever a gate turns on. Turn-off is never delayed, so both switches of a leg are never on together.

The sequencer also supervises the bridge. An overvoltage or undervoltage alarm forces all gates off while it is present and raises a diagnostic output. When the alarm clears, the bridge resumes without any other action. Each transistor has a short-circuit comparator input. A short is acted on only after it has persisted, while its transistor is on, for a configurable number of clock cycles. A confirmed short is latched and keeps the bridge off until the enable input is taken low and then high again. A change of direction first switches every gate off and waits out the dead time before the new pattern is applied. All control inputs are asynchronous and pass through a two-stage synchronizer before use.

Top module: `hbridge_gate_seq`

## Requirements
- R1: While reset is asserted and in the first cycle after it, all four gate outputs, `supply_diag` and `sc_fault` are low.
- R2: With enable high, direction high and no fault, the steady pattern is `gate_hs[0]`=PWM, `gate_ls[0]`=not PWM, `gate_hs[1]`=0 and `gate_ls[1]`=1.
- R3: With enable high, direction low and no fault, the steady pattern is `gate_hs[1]`=PWM, `gate_ls[1]`=not PWM, `gate_hs[0]`=0 and `gate_ls[0]`=1.
- R4: When enable is low, all four gates are off, and the cycle after the synchronized enable goes low they are off.
- R5: In a leg, once a gate turns off, the other gate of that leg turns on exactly D cycles later when it is requested, where D is the effective dead time. During those D cycles both gates of the leg are off. Turn-off is not delayed by the dead time.
- R6: The effective dead time D equals `dead_cfg`, except that a value of 0 is treated as 1 cycle.
- R7: The high-side and low-side gates of one leg are never on in the same cycle.
- R8: After a direction change, all four gates are off for at least D consecutive cycles before the new direction's pattern appears.
- R9: While an overvoltage or undervoltage alarm is active, all gates are off and `supply_diag` is high. After the alarm clears, `supply_diag` falls and normal switching resumes with no latching.
- R10: `sc_fault` is set only after a comparator bit has stayed high for SC_HOLD consecutive synchronized cycles while its gate is on. A shorter run does not set it. Comparator bit mapping: 0 = high side leg 0, 1 = high side leg 1, 2 = low side leg 0, 3 = low side leg 1.
- R11: While `sc_fault` is set, all gates stay off, even after the comparator clears. The fault clears only while enable is low, and switching restarts when enable returns high. A comparator that is high while its gate is off has no effect.
- R12: The gates respond to a pin change on the third rising clock edge after it: two synchronizer stages plus one output register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| en_in | input | 1 | Bridge enable (asynchronous) |
| pwm_in | input | 1 | PWM command (asynchronous) |
| dir_in | input | 1 | Direction command (asynchronous) |
| ov_in | input | 1 | Overvoltage alarm (asynchronous) |
| uv_in | input | 1 | Undervoltage alarm (asynchronous) |
| short_in | input | 4 | Per-transistor short comparators, mapping as in R10 |
| dead_cfg | input | DT_W | Dead time in clock cycles, with 0 treated as 1 |
| gate_hs | output | 2 | High-side gate enables, index = leg |
| gate_ls | output | 2 | Low-side gate enables, index = leg |
| supply_diag | output | 1 | Supply alarm diagnostic flag |
| sc_fault | output | 1 | Latched confirmed short-circuit flag |

## Verification
The embedded assertions check four things on every cycle: no leg ever conducts on both sides, a gate only rises after its partner was off, supply alarms, a low enable, a pending direction reversal or a latched short always leave the bridge off on the next cycle, and a latched short persists while enable stays high. The exact dead-time length for each `dead_cfg` value, the three-cycle input latency, and the exact persistence boundary of short qualification can only be shown by the bench's scenarios. The same holds for the length of the all-off window on reversal and for the release of the latch through an enable cycle.

// File: rtl/hbs_pkg.sv
package hbs_pkg;

  // Number of synchronized control lines: en, pwm, dir, ov, uv, 4 x short
  localparam int unsigned NUM_CTRL = 9;

  // Dead time actually applied: a zero setting still gives one cycle
  function automatic int unsigned eff_dead(input int unsigned cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

  // Gate request for a direction and PWM level, packed {ls1, ls0, hs1, hs0}
  function automatic logic [3:0] drive_pattern(input logic dir, input logic pwm);
    logic [3:0] p;
    if (dir) begin
      p[0] = pwm;     // hs leg0
      p[2] = ~pwm;    // ls leg0
      p[1] = 1'b0;    // hs leg1
      p[3] = 1'b1;    // ls leg1 recirculation
    end else begin
      p[1] = pwm;
      p[3] = ~pwm;
      p[0] = 1'b0;
      p[2] = 1'b1;
    end
    return p;
  endfunction

endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int unsigned W      = 1,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] async_in,
  output logic [W-1:0] sync_out
);
  logic [W-1:0] stage [STAGES];

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[0] <= '0;
          else        stage[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stage[g] <= '0;
          else        stage[g] <= stage[g-1];
        end
      end
    end
  endgenerate

  assign sync_out = stage[STAGES-1];
endmodule

// File: rtl/hbs_leg.sv
module hbs_leg #(
  parameter int unsigned DT_W = 6
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [DT_W-1:0] dead_cycles,  // effective, never 0
  input  logic            want_hs,
  input  logic            want_ls,
  output logic            hs,
  output logic            ls
);
  localparam logic [DT_W-1:0] CNT_MAX = '1;

  logic [DT_W-1:0] idle_cnt;
  logic            gap_done;
  logic            hs_next;
  logic            ls_next;

  always_comb begin
    gap_done = ({1'b0, idle_cnt} + (DT_W+1)'(1)) >= {1'b0, dead_cycles};
    hs_next  = want_hs && !want_ls && (hs || (!ls && gap_done));
    ls_next  = want_ls && !want_hs && (ls || (!hs && gap_done));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hs       <= 1'b0;
      ls       <= 1'b0;
      idle_cnt <= '0;
    end else begin
      hs <= hs_next;
      ls <= ls_next;
      if (hs || ls)                 idle_cnt <= '0;
      else if (idle_cnt != CNT_MAX) idle_cnt <= idle_cnt + 1'b1;
    end
  end

  // R7
  no_shoot_chk: assert property (@(posedge clk) disable iff (!rst_n) !(hs && ls));
  // R5
  hs_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(hs) |-> $past(!ls));
  // R5
  ls_gap_chk: assert property (@(posedge clk) disable iff (!rst_n) $rose(ls) |-> $past(!hs));
  // R5
  fast_off_chk: assert property (@(posedge clk) disable iff (!rst_n) (hs && !want_hs) |=> !hs);
endmodule

// File: rtl/hbs_sc_qual.sv
module hbs_sc_qual #(
  parameter int unsigned HOLD = 500000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cmp,
  input  logic gate_on,
  output logic trip
);
  localparam int unsigned CW = $clog2(HOLD + 1);
  localparam logic [CW-1:0] LAST = CW'(HOLD - 1);

  logic [CW-1:0] run;
  logic          armed;

  assign armed = cmp && gate_on;
  assign trip  = armed && (run == LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       run <= '0;
    else if (!armed)  run <= '0;
    else if (!trip)   run <= run + 1'b1;
  end

  // R10
  run_chk: assert property (@(posedge clk) disable iff (!rst_n) (run != '0) |-> $past(armed));
endmodule

// File: rtl/hbridge_gate_seq.sv
module hbridge_gate_seq #(
  parameter int unsigned DT_W        = 6,
  parameter int unsigned SC_HOLD     = 500000,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            en_in,
  input  logic            pwm_in,
  input  logic            dir_in,
  input  logic            ov_in,
  input  logic            uv_in,
  input  logic [3:0]      short_in,
  input  logic [DT_W-1:0] dead_cfg,
  output logic [1:0]      gate_hs,
  output logic [1:0]      gate_ls,
  output logic            supply_diag,
  output logic            sc_fault
);
  import hbs_pkg::*;

  localparam logic [DT_W-1:0] CNT_MAX = '1;

  logic [NUM_CTRL-1:0] raw_ctrl;
  logic [NUM_CTRL-1:0] syn_ctrl;
  logic                s_en, s_pwm, s_dir, s_ov, s_uv;
  logic [3:0]          s_short;
  logic [DT_W-1:0]     dead_eff;
  logic                supply_bad;
  logic                dir_applied;
  logic                dir_pending;
  logic                blocked;
  logic [3:0]          want;
  logic [3:0]          gates;
  logic                all_off;
  logic [DT_W-1:0]     rev_cnt;
  logic                rev_ready;
  logic [3:0]          trips;

  assign raw_ctrl = {short_in, uv_in, ov_in, dir_in, pwm_in, en_in};

  hbs_sync #(.W(NUM_CTRL), .STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .async_in(raw_ctrl), .sync_out(syn_ctrl)
  );

  assign {s_short, s_uv, s_ov, s_dir, s_pwm, s_en} = syn_ctrl;

  assign dead_eff    = DT_W'(eff_dead(32'(dead_cfg)));
  assign supply_bad  = s_ov || s_uv;
  assign dir_pending = (s_dir != dir_applied);
  assign blocked     = !s_en || supply_bad || sc_fault || dir_pending;
  assign want        = blocked ? 4'b0000 : drive_pattern(dir_applied, s_pwm);
  assign gates       = {gate_ls, gate_hs};
  assign all_off     = (gates == 4'b0000);
  assign rev_ready   = all_off && (({1'b0, rev_cnt} + (DT_W+1)'(1)) >= {1'b0, dead_eff});

  genvar l;
  generate
    for (l = 0; l < 2; l++) begin : g_leg
      hbs_leg #(.DT_W(DT_W)) u_leg (
        .clk(clk), .rst_n(rst_n), .dead_cycles(dead_eff),
        .want_hs(want[l]), .want_ls(want[l+2]),
        .hs(gate_hs[l]), .ls(gate_ls[l])
      );
    end
  endgenerate

  genvar t;
  generate
    for (t = 0; t < 4; t++) begin : g_sc
      hbs_sc_qual #(.HOLD(SC_HOLD)) u_qual (
        .clk(clk), .rst_n(rst_n), .cmp(s_short[t]),
        .gate_on(gates[t]), .trip(trips[t])
      );
    end
  endgenerate

  // Direction reversal: all gates off, wait the dead time, then take the new direction
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rev_cnt     <= '0;
      dir_applied <= 1'b0;
    end else begin
      if (!all_off)               rev_cnt <= '0;
      else if (rev_cnt != CNT_MAX) rev_cnt <= rev_cnt + 1'b1;
      if (dir_pending && rev_ready) dir_applied <= s_dir;
    end
  end

  // Fault flags
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      supply_diag <= 1'b0;
      sc_fault    <= 1'b0;
    end else begin
      supply_diag <= supply_bad;
      if (!s_en)       sc_fault <= 1'b0;
      else if (|trips) sc_fault <= 1'b1;
    end
  end

  // R9
  supply_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    supply_bad |=> (gates == 4'b0000) && supply_diag);
  // R4
  enable_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !s_en |=> (gates == 4'b0000));
  // R8
  reverse_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dir_pending |=> (gates == 4'b0000));
  // R11
  latch_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fault |=> (gates == 4'b0000));
  // R11
  latch_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fault && s_en) |=> sc_fault);
endmodule

// File: tb/hbridge_gate_seq_test.sv
module hbridge_gate_seq_test;
  localparam int unsigned DT_W = 6;
  localparam int unsigned HOLD = 8;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            en_in = 1'b0, pwm_in = 1'b0, dir_in = 1'b0, ov_in = 1'b0, uv_in = 1'b0;
  logic [3:0]      short_in = 4'b0;
  logic [DT_W-1:0] dead_cfg = '0;
  logic [1:0]      gate_hs, gate_ls;
  logic            supply_diag, sc_fault;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;  // 50 MHz

  hbridge_gate_seq #(.DT_W(DT_W), .SC_HOLD(HOLD)) uut (
    .clk(clk), .rst_n(rst_n), .en_in(en_in), .pwm_in(pwm_in), .dir_in(dir_in),
    .ov_in(ov_in), .uv_in(uv_in), .short_in(short_in), .dead_cfg(dead_cfg),
    .gate_hs(gate_hs), .gate_ls(gate_ls), .supply_diag(supply_diag), .sc_fault(sc_fault)
  );

  task automatic tick(input int n = 1);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int deff(input int cfg);
    return (cfg == 0) ? 1 : cfg;
  endfunction

  // expected {ls, hs} steady pattern, 4 bits {ls1,ls0,hs1,hs0}
  function automatic int pat(input bit dir, input bit pwm);
    int hs, ls;
    if (dir) begin hs = pwm ? 1 : 0; ls = pwm ? 2 : 3; end
    else     begin hs = pwm ? 2 : 0; ls = pwm ? 1 : 3; end
    return ls * 4 + hs;
  endfunction

  function automatic int gates_now();
    return int'({gate_ls, gate_hs});
  endfunction

  int dl [14] = '{0, 1, 2, 3, 4, 5, 6, 7, 9, 12, 17, 31, 62, 63};

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int first_off, first_on, run, best;
    tick(4);
    // R1 reset state
    check("R1 gates in reset", gates_now(), 0);
    check("R1 diag in reset", supply_diag, 0);
    check("R1 sc_fault in reset", sc_fault, 0);
    rst_n = 1'b1;
    tick(1);
    check("R1 gates after reset", gates_now(), 0);

    // R2 / R3 steady patterns
    dead_cfg = 3; en_in = 1; dir_in = 1; pwm_in = 1; tick(30);
    check("R2 dir1 pwm1", gates_now(), pat(1, 1));
    pwm_in = 0; tick(30);
    check("R2 dir1 pwm0", gates_now(), pat(1, 0));
    dir_in = 0; pwm_in = 1; tick(40);
    check("R3 dir0 pwm1", gates_now(), pat(0, 1));
    pwm_in = 0; tick(30);
    check("R3 dir0 pwm0", gates_now(), pat(0, 0));

    // R5 / R6 / R12 dead-time sweep on leg 0
    dir_in = 1; tick(150);
    foreach (dl[i]) begin
      dead_cfg = DT_W'(dl[i]); pwm_in = 0; tick(150);
      pwm_in = 1; first_off = 0; first_on = 0;
      for (int k = 1; k <= 100; k++) begin
        tick(1);
        if (!gate_ls[0] && first_off == 0) first_off = k;
        if (gate_hs[0] && first_on == 0) first_on = k;
      end
      check("R12 rise latency", first_off, 3);
      check(dl[i] == 0 ? "R6 zero dead rise" : "R5 dead rise", first_on - first_off, deff(dl[i]));
      pwm_in = 0; first_off = 0; first_on = 0;
      for (int k = 1; k <= 100; k++) begin
        tick(1);
        if (!gate_hs[0] && first_off == 0) first_off = k;
        if (gate_ls[0] && first_on == 0) first_on = k;
      end
      check("R12 fall latency", first_off, 3);
      check(dl[i] == 0 ? "R6 zero dead fall" : "R5 dead fall", first_on - first_off, deff(dl[i]));
    end

    // R8 direction change windows
    foreach (dl[i]) begin
      if (i == 1 || i == 5 || i == 10) begin
        dead_cfg = DT_W'(dl[i]); dir_in = 1; pwm_in = 1; tick(150);
        dir_in = 0; run = 0; best = 0;
        for (int k = 0; k < 150; k++) begin
          tick(1);
          if (gates_now() == 0) begin run++; if (run > best) best = run; end
          else run = 0;
        end
        check("R8 all-off window", best >= deff(dl[i]), 1);
        check("R8 new pattern", gates_now(), pat(0, 1));
      end
    end

    // R4 enable low
    dead_cfg = 2; dir_in = 1; pwm_in = 1; tick(150);
    en_in = 0; tick(2);
    check("R4 still on before latency", gates_now(), pat(1, 1));
    tick(1);
    check("R4 off after enable low", gates_now(), 0);
    tick(20);
    check("R4 stays off", gates_now(), 0);
    en_in = 1; tick(30);
    check("R4 resumes", gates_now(), pat(1, 1));

    // R9 supply alarms
    ov_in = 1; tick(3);
    check("R9 ov gates off", gates_now(), 0);
    check("R9 ov diag", supply_diag, 1);
    tick(10);
    check("R9 ov held", gates_now(), 0);
    ov_in = 0; tick(30);
    check("R9 ov cleared diag", supply_diag, 0);
    check("R9 ov resumes", gates_now(), pat(1, 1));
    uv_in = 1; tick(3);
    check("R9 uv gates off", gates_now(), 0);
    check("R9 uv diag", supply_diag, 1);
    uv_in = 0; tick(30);
    check("R9 uv resumes", gates_now(), pat(1, 1));

    // R11 short on an off gate (hs leg1) is ignored
    short_in[1] = 1; tick(40); short_in[1] = 0; tick(5);
    check("R11 off-gate short ignored", sc_fault, 0);
    check("R11 off-gate pattern", gates_now(), pat(1, 1));

    // R10 qualification boundary on ls leg1 (bit 3)
    short_in[3] = 1; tick(HOLD - 1); short_in[3] = 0; tick(15);
    check("R10 short pulse below hold", sc_fault, 0);
    check("R10 pattern intact", gates_now(), pat(1, 1));
    short_in[3] = 1; tick(HOLD); short_in[3] = 0; tick(15);
    check("R10 short pulse at hold", sc_fault, 1);
    check("R10 gates off", gates_now(), 0);

    // R11 latch held, cleared by enable cycle
    tick(40);
    check("R11 latch held", sc_fault, 1);
    check("R11 gates held off", gates_now(), 0);
    en_in = 0; tick(10);
    check("R11 latch cleared by enable low", sc_fault, 0);
    en_in = 1; tick(30);
    check("R11 restart", gates_now(), pat(1, 1));

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule